// File: doc/BRIEF.md
# Chained-Descriptor Outbound Byte DMA

This block is the send half of a DMA channel that follows a linked chain of data descriptors held in word-addressed memory. Software builds the chain, then pulses a start input with the address of the first descriptor and the address of the context descriptor that owns the chain. The engine fetches each descriptor, streams every byte of the buffer span it names to a peripheral over a valid/ready byte stream, writes the descriptor back, and then moves on.

A span runs from a start address up to, but not including, an end address, so no length field exists. When a descriptor flagged as last in the chain completes, the engine marks the context descriptor as disabled in memory. It then sets a sticky end-of-chain flag and goes idle. While that flag is set the engine refuses new work until it is cleared explicitly. Completion of a descriptor can raise a sticky interrupt bit, and a descriptor can ask for a packet-end marker on its final byte.

Top module: `dsc_out_dma`

## Requirements
- R1: After reset, busy_o, eol_o, intr_raw_o, st_valid_o and mem_req_o are all low, and they stay low while the engine is idle.
- R2: A descriptor is four words read from its base address at offsets 0, 4, 8 and 12. They hold, in that order, the next-descriptor address, the span start, the flags word and the span end.
- R3: The bytes from start to end-1 are sent in ascending address order. The byte at address A is lane A[1:0] of the word at A with its two low bits cleared, where lane 0 is bits 7:0.
- R4: While st_valid_o is high and st_ready_i is low, st_valid_o, st_data_o and st_last_o hold their values.
- R5: When flags bit 3 is set, st_last_o is high with the final byte of that descriptor's span and with no other byte. When flags bit 3 is clear, st_last_o never rises.
- R6: When flags bit 4 is set, completing the span sets intr_raw_o bit 2. The bit stays set until a cycle with intr_ack_i bit 2 high.
- R7: After its span, each descriptor is written back as four words at its own four addresses, with the contents as fetched.
- R8: When flags bit 0 (end of chain) is clear, the next descriptor is fetched from the address in word 0.
- R9: When flags bit 0 is set, the word at context address + 4 is read and written back with bit 15 set and its other bits kept. Then eol_o rises and busy_o falls.
- R10: While eol_o is high, start_i has no effect. A pulse on eol_clr_i while idle clears eol_o.
- R11: A span whose end equals its start produces no stream beats but still raises the interrupt and performs the writeback and chaining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when idle and eol_o is low |
| desc_addr_i | input | W | Address of the first descriptor |
| ctx_addr_i | input | W | Address of the owning context descriptor |
| eol_clr_i | input | 1 | Clears the sticky end-of-chain flag while idle |
| busy_o | output | 1 | Engine is walking a chain |
| eol_o | output | 1 | Sticky end-of-chain flag |
| intr_ack_i | input | IRQW | Per-bit interrupt acknowledge |
| intr_raw_o | output | IRQW | Raw interrupt bits, bit 2 for descriptor completion |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | W | Byte address of the word accessed |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid one cycle after the read request |
| st_valid_o | output | 1 | Stream byte valid |
| st_data_o | output | 8 | Stream byte |
| st_last_o | output | 1 | Packet-end marker on the final byte |
| st_ready_i | input | 1 | Stream sink ready |

## Verification
The bench runs spans that begin and end at unaligned byte lanes. A lane-select or end-compare error would then show up as a wrong byte or a count off by one. An empty span is checked for zero beats while its interrupt and writeback still happen; an engine that tested for the end only after sending would emit a stray byte. A two-descriptor chain is run under alternating backpressure. A design that dropped or changed bytes during a stall, or that ignored the next pointer, would break the byte order. Counting writeback cycles catches a design that skips the store-back or writes the advanced pointer. Checking that a start is ignored while the end-of-chain flag is set catches an engine that restarts on its own.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RD, S_LAT, S_SEND, S_WB, S_CRD, S_CLAT, S_CWR
  } dsd_state_e;

  localparam int DESC_WORDS = 4;
  localparam int F_EOL      = 0;
  localparam int F_OEOP     = 3;
  localparam int F_IRQ      = 4;
  localparam int CTX_DIS    = 15;
  localparam int IRQ_DATA   = 2;
  localparam int CTX_FLAGS_OFS = 4;
endpackage

// File: rtl/dsd_lane_pick.sv
module dsd_lane_pick #(
  parameter int W = 32,
  localparam int LANES = W / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic [W-1:0]  word_i,
  input  logic [LB-1:0] sel_i,
  output logic [7:0]    byte_o
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end

  assign byte_o = lanes[sel_i];
endmodule

// File: rtl/dsd_irq_reg.sv
module dsd_irq_reg #(
  parameter int IRQW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IRQW-1:0] set_i,
  input  logic [IRQW-1:0] ack_i,
  output logic [IRQW-1:0] raw_o
);
  logic [IRQW-1:0] raw_q, raw_d;

  always_comb raw_d = (raw_q & ~ack_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/dsc_out_dma.sv
module dsc_out_dma
  import dsd_pkg::*;
#(
  parameter int W    = 32,
  parameter int IRQW = 4,
  localparam int LB  = $clog2(W / 8)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [W-1:0]    desc_addr_i,
  input  logic [W-1:0]    ctx_addr_i,
  input  logic            eol_clr_i,
  output logic            busy_o,
  output logic            eol_o,
  input  logic [IRQW-1:0] intr_ack_i,
  output logic [IRQW-1:0] intr_raw_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [W-1:0]    mem_addr_o,
  output logic [W-1:0]    mem_wdata_o,
  input  logic [W-1:0]    mem_rdata_i,
  output logic            st_valid_o,
  output logic [7:0]      st_data_o,
  output logic            st_last_o,
  input  logic            st_ready_i
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  dsd_state_e state_q, state_d;
  logic [2:0]   idx_q, idx_d;
  logic [W-1:0] dptr_q, dptr_d, cptr_q, cptr_d, cur_q, cur_d, ctxw_q, ctxw_d;
  logic [W-1:0] w_q [DESC_WORDS];
  logic [W-1:0] w_d [DESC_WORDS];
  logic [7:0]   byte_q, byte_d, lane_byte;
  logic         eol_q, eol_d;
  logic [IRQW-1:0] irq_set;

  dsd_lane_pick #(.W(W)) u_lane (
    .word_i (mem_rdata_i),
    .sel_i  (cur_q[LB-1:0]),
    .byte_o (lane_byte)
  );

  dsd_irq_reg #(.IRQW(IRQW)) u_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (irq_set),
    .ack_i (intr_ack_i),
    .raw_o (intr_raw_o)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    dptr_d  = dptr_q;
    cptr_d  = cptr_q;
    cur_d   = cur_q;
    ctxw_d  = ctxw_q;
    byte_d  = byte_q;
    eol_d   = eol_q;
    w_d     = w_q;
    irq_set     = '0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    st_valid_o  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (eol_clr_i) eol_d = 1'b0;
        if (start_i && !eol_q) begin
          dptr_d  = desc_addr_i;
          cptr_d  = ctx_addr_i;
          idx_d   = '0;
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        if (idx_q < 3'(DESC_WORDS)) begin
          mem_req_o  = 1'b1;
          mem_addr_o = dptr_q + W'({idx_q, 2'b00});
        end
        if (idx_q != '0) begin
          w_d[idx_q[1:0] - 2'd1] = mem_rdata_i;
          if (idx_q == 3'd2) cur_d = mem_rdata_i;
        end
        if (idx_q == 3'(DESC_WORDS)) begin
          idx_d   = '0;
          state_d = S_CHECK;
        end else begin
          idx_d = idx_q + 3'd1;
        end
      end
      S_CHECK: begin
        if (cur_q == w_q[3]) begin
          if (w_q[2][F_IRQ]) irq_set[IRQ_DATA] = 1'b1;
          idx_d   = '0;
          state_d = S_WB;
        end else begin
          state_d = S_RD;
        end
      end
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {cur_q[W-1:LB], {LB{1'b0}}};
        state_d    = S_LAT;
      end
      S_LAT: begin
        byte_d  = lane_byte;
        state_d = S_SEND;
      end
      S_SEND: begin
        st_valid_o = 1'b1;
        if (st_ready_i) begin
          cur_d   = cur_q + W'(1);
          state_d = S_CHECK;
        end
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dptr_q + W'({idx_q, 2'b00});
        mem_wdata_o = w_q[idx_q[1:0]];
        if (idx_q == 3'(DESC_WORDS - 1)) begin
          idx_d = '0;
          if (w_q[2][F_EOL]) begin
            state_d = S_CRD;
          end else begin
            dptr_d  = w_q[0];
            state_d = S_FETCH;
          end
        end else begin
          idx_d = idx_q + 3'd1;
        end
      end
      S_CRD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cptr_q + W'(CTX_FLAGS_OFS);
        state_d    = S_CLAT;
      end
      S_CLAT: begin
        ctxw_d  = mem_rdata_i | (W'(1) << CTX_DIS);
        state_d = S_CWR;
      end
      S_CWR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cptr_q + W'(CTX_FLAGS_OFS);
        mem_wdata_o = ctxw_q;
        eol_d       = 1'b1;
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      dptr_q  <= '0;
      cptr_q  <= '0;
      cur_q   <= '0;
      ctxw_q  <= '0;
      byte_q  <= '0;
      eol_q   <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) w_q[i] <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dptr_q  <= dptr_d;
      cptr_q  <= cptr_d;
      cur_q   <= cur_d;
      ctxw_q  <= ctxw_d;
      byte_q  <= byte_d;
      eol_q   <= eol_d;
      for (int i = 0; i < DESC_WORDS; i++) w_q[i] <= w_d[i];
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign eol_o     = eol_q;
  assign st_data_o = byte_q;
  assign st_last_o = st_valid_o && w_q[2][F_OEOP] && ((cur_q + W'(1)) == w_q[3]);
endmodule

// File: rtl/dsc_out_dma_chk.sv
module dsc_out_dma_chk #(
  parameter int IRQW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            eol_o,
  input logic [IRQW-1:0] intr_ack_i,
  input logic [IRQW-1:0] intr_raw_o,
  input logic            mem_req_o,
  input logic            st_valid_o,
  input logic [7:0]      st_data_o,
  input logic            st_last_o,
  input logic            st_ready_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!st_valid_o && !mem_req_o)); // R1

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_data_o) && $stable(st_last_o))); // R4

  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    st_last_o |-> st_valid_o); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_raw_o[2] && !intr_ack_i[2]) |=> intr_raw_o[2]); // R6

  AST_EOL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |-> !busy_o); // R9

  AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_o && start_i) |=> !busy_o); // R10
endmodule

bind dsc_out_dma dsc_out_dma_chk #(.IRQW(IRQW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .eol_o      (eol_o),
  .intr_ack_i (intr_ack_i),
  .intr_raw_o (intr_raw_o),
  .mem_req_o  (mem_req_o),
  .st_valid_o (st_valid_o),
  .st_data_o  (st_data_o),
  .st_last_o  (st_last_o),
  .st_ready_i (st_ready_i)
);

// File: tb/test_dsc_out_dma.sv
module test_dsc_out_dma;
  localparam int W = 32;
  localparam int IRQW = 4;
  // {start, end, out_eop, irq}
  localparam logic [17:0] VEC [4] = '{
    {8'h81, 8'h86, 1'b1, 1'b1},
    {8'h80, 8'h84, 1'b0, 1'b0},
    {8'h83, 8'h84, 1'b1, 1'b0},
    {8'h90, 8'h90, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start_i, eol_clr_i, busy_o, eol_o;
  logic [W-1:0] desc_addr_i, ctx_addr_i;
  logic [IRQW-1:0] intr_ack_i, intr_raw_o;
  logic mem_req_o, mem_we_o;
  logic [W-1:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic st_valid_o, st_last_o, st_ready_i;
  logic [7:0] st_data_o;

  dsc_out_dma #(.W(W), .IRQW(IRQW)) i_dsc_out_dma (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_addr_i(desc_addr_i),
    .ctx_addr_i(ctx_addr_i), .eol_clr_i(eol_clr_i), .busy_o(busy_o), .eol_o(eol_o),
    .intr_ack_i(intr_ack_i), .intr_raw_o(intr_raw_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .st_valid_o(st_valid_o), .st_data_o(st_data_o),
    .st_last_o(st_last_o), .st_ready_i(st_ready_i)
  );

  // memory model: one-cycle read latency, plus a bench setup port
  logic [31:0] mem [64];
  logic        tb_we;
  logic [7:0]  tb_a;
  logic [31:0] tb_wd;
  logic        cap_clr;
  logic [8:0]  wb_cnt;

  always @(posedge clk) begin
    if (cap_clr) wb_cnt <= '0;
    if (tb_we) mem[tb_a[7:2]] <= tb_wd;
    else if (mem_req_o) begin
      if (mem_we_o) begin
        mem[mem_addr_o[7:2]] <= mem_wdata_o;
        if (mem_addr_o[7:0] < 8'h20 && !cap_clr) wb_cnt <= wb_cnt + 9'd1;
      end else mem_rdata_i <= mem[mem_addr_o[7:2]];
    end
  end

  // stream monitor
  logic [7:0] cap_d [256];
  logic       cap_l [256];
  logic [8:0] ncap;
  logic [8:0] stall_err;
  logic pv, pr, pl;
  logic [7:0] pd;
  logic stall_mode;

  always @(posedge clk) begin
    if (cap_clr) begin
      ncap <= '0;
      stall_err <= '0;
    end else begin
      if (st_valid_o && st_ready_i && ncap < 9'd256) begin
        cap_d[ncap[7:0]] <= st_data_o;
        cap_l[ncap[7:0]] <= st_last_o;
        ncap <= ncap + 9'd1;
      end
      if (pv && !pr && (!st_valid_o || st_data_o != pd || st_last_o != pl))
        stall_err <= stall_err + 9'd1;
    end
    pv <= st_valid_o; pr <= st_ready_i; pd <= st_data_o; pl <= st_last_o;
  end

  always @(negedge clk) begin
    if (!rst_n) st_ready_i <= 1'b1;
    else st_ready_i <= stall_mode ? ~st_ready_i : 1'b1;
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] eb(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [31:0] d);
    tb_we = 1'b1; tb_a = a; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic pulse_clear();
    intr_ack_i = '1; eol_clr_i = 1'b1; cap_clr = 1'b1;
    @(negedge clk);
    intr_ack_i = '0; eol_clr_i = 1'b0; cap_clr = 1'b0;
  endtask

  task automatic go();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!eol_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog (run hung) act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; eol_clr_i = 1'b0; intr_ack_i = '0;
    desc_addr_i = 32'h0; ctx_addr_i = 32'h20; tb_we = 1'b0; tb_a = '0; tb_wd = '0;
    cap_clr = 1'b1; stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cap_clr = 1'b0;
    // R1 reset state
    chk(!busy_o && !eol_o && intr_raw_o == '0 && !st_valid_o && !mem_req_o, "R1 reset state",
        {busy_o, eol_o, intr_raw_o, st_valid_o, mem_req_o}, 0);

    for (int a = 8'h80; a < 256; a += 4)
      mwrite(8'(a), {eb(8'(a + 3)), eb(8'(a + 2)), eb(8'(a + 1)), eb(8'(a))});

    // vector table: single-descriptor chains
    for (int v = 0; v < 4; v++) begin
      logic [7:0] s, e;
      logic eop, irq;
      logic [31:0] fl;
      int bad, lbad;
      {s, e, eop, irq} = VEC[v];
      fl = 32'hA5C3_0000 | 32'h1 | (32'(eop) << 3) | (32'(irq) << 4);
      mwrite(8'h00, 32'h10); mwrite(8'h04, 32'(s)); mwrite(8'h08, fl); mwrite(8'h0C, 32'(e));
      mwrite(8'h24, 32'h0000_1234);
      pulse_clear();
      go();
      chk(ncap == 9'(e - s), "R2 R3 beat count", 32'(ncap), 32'(e - s));
      bad = 0; lbad = 0;
      for (int i = 0; i < 256; i++) if (i < int'(ncap)) begin
        if (cap_d[i] != eb(8'(s + i))) bad++;
        if (cap_l[i] != (eop && i == int'(ncap) - 1)) lbad++;
      end
      chk(bad == 0, "R3 byte order/lanes", bad, 0);
      chk(lbad == 0, "R5 last marker", lbad, 0);
      if (s == e) chk(ncap == 0, "R11 empty span no beats", 32'(ncap), 0);
      chk(intr_raw_o[2] == irq, "R6 irq on completion", 32'(intr_raw_o), 32'(irq) << 2);
      chk(wb_cnt == 9'd4 && mem[1] == 32'(s) && mem[2] == fl && mem[3] == 32'(e),
          "R7 writeback", 32'(wb_cnt), 4);
      chk(mem[9] == 32'h0000_9234, "R9 context disable bit", mem[9], 32'h9234);
      chk(eol_o && !busy_o, "R9 eol set, idle", {eol_o, busy_o}, 2);
    end

    // R6 acknowledge clears the sticky bit
    intr_ack_i = 4'b0100;
    @(negedge clk);
    intr_ack_i = '0;
    chk(intr_raw_o[2] == 1'b0, "R6 ack clears", 32'(intr_raw_o), 0);

    // R10 start ignored while eol is set
    cap_clr = 1'b1; @(negedge clk); cap_clr = 1'b0;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy_o && ncap == 0 && wb_cnt == 0, "R10 start ignored", {busy_o, 9'(ncap)}, 0);
    eol_clr_i = 1'b1; @(negedge clk); eol_clr_i = 1'b0;
    chk(!eol_o, "R10 eol clear", 32'(eol_o), 0);

    // R8 chain of two descriptors under backpressure (R4)
    stall_mode = 1'b1;
    mwrite(8'h00, 32'h10); mwrite(8'h04, 32'h84); mwrite(8'h08, 32'hA5C3_0000); mwrite(8'h0C, 32'h87);
    mwrite(8'h10, 32'h00); mwrite(8'h14, 32'hA1); mwrite(8'h18, 32'h0000_0009); mwrite(8'h1C, 32'hA3);
    mwrite(8'h24, 32'h0000_0001);
    pulse_clear();
    go();
    begin
      logic [7:0] expb [5];
      int bad;
      expb = '{eb(8'h84), eb(8'h85), eb(8'h86), eb(8'hA1), eb(8'hA2)};
      chk(ncap == 9'd5, "R8 chained beat count", 32'(ncap), 5);
      bad = 0;
      for (int i = 0; i < 5; i++)
        if (cap_d[i] != expb[i] || cap_l[i] != (i == 4)) bad++;
      chk(bad == 0, "R8 chained bytes and last", bad, 0);
    end
    chk(stall_err == 0, "R4 stable under stall", 32'(stall_err), 0);
    chk(wb_cnt == 9'd8, "R7 writeback per descriptor", 32'(wb_cnt), 8);
    chk(mem[9] == 32'h0000_8001, "R9 context bits kept", mem[9], 32'h8001);
    stall_mode = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule